// File: doc/BRIEF.md
# Oscillator Command and Mode Controller

This block sits behind a single-wire line receiver and turns the bytes it delivers into actions on a programmable clock source. The first byte of each command is an opcode. The opcode fixes how many argument bytes follow. The command takes effect only once its last argument byte has been received.

The controller tracks five operating modes: Run, Stop, Doze, Sleep and a frequency-setup state used while the oscillator recalibrates. It holds four settings: the base-frequency word, an absolute frequency offset, a drive-strength code and a power/jitter preference. It produces the output enable, two power-down controls and a recalibration request. It accepts a recalibration-done pulse back.

Bytes arrive on a valid/ready stream. A byte moves on a cycle in which both `in_valid` and `in_ready` are high. `in_ready` falls for one cycle after every completed command. It also stays low for the whole frequency-setup state. A sender holding a byte must keep `in_valid` and `in_data` steady until the byte is taken.

Top module: `osc_cmd_ctrl`

## Requirements
- R1: After reset the block has the following state:
  - mode is Run (code 0) and `out_en` is 1;
  - `base_freq` is the FACTORY_FREQ parameter and `freq_offset` is 0;
  - `drive` is DEF_DRIVE and `low_jitter` is DEF_LOW_JITTER;
  - `recal_req`, `vco_pd` and `core_pd` are 0.
- R2: Bytes taken before a `setup_seen` pulse are dropped. This applies after reset and again after each wake from Sleep.
- R3: The opcodes and their argument counts are: 0x50 Run (0), 0x18 Stop (0), 0x20 Doze (0), 0x30 Sleep (0), 0x0C NewFreq (4), 0x10 OriginalFreq (0), 0x3A OffsetFreq (2), 0x41 DrvStrength (1), 0x49 PwrJitter (1) and 0x00 NoOp (0). Arguments arrive most significant byte first. Any other opcode acts as NoOp with no arguments.
- R4: A `setup_seen` or `abort` pulse drops a partly received command, including one that arrives in the same cycle as the last argument byte. The next byte taken is then decoded as an opcode.
- R5: Stop, Doze and Sleep are reached from Run. When mode leaves Run, `out_en` falls only on a cycle where `last_cycle_done` is high. `out_en` rises again one cycle after mode returns to Run.
- R6: NewFreq or OriginalFreq received in Run takes these steps:
  - it loads the base word (the argument, or FACTORY_FREQ) and clears the offset;
  - it enters frequency setup (code 4) with `recal_req` high;
  - it returns to Run one cycle after `recal_done`.
- R7: NewFreq, OriginalFreq and OffsetFreq received in Stop or Doze are held and applied on the next Run command, with the last value written winning. NewFreq and OriginalFreq also schedule a cleared offset. A held base word makes that Run pass through frequency setup.
- R8: OffsetFreq in Run replaces the offset with its 16-bit signed argument at once. Offsets do not accumulate.
- R9: A PwrJitter value (argument bit 0, 1 meaning low jitter) is held until the next mode change. A Run command received in Run counts as a mode change.
- R10: A DrvStrength argument from 0 to 7 replaces `drive` at once. Values above 7 are ignored.
- R11: In Sleep (code 3), both bytes and `setup_seen` are ignored. A `line_edge` pulse wakes the block toward Run and applies held settings, as a Run command would.
- R12: `vco_pd` is high in Doze (code 2) and in Sleep once `out_en` is low. `core_pd` is high in Sleep once `out_en` is low.
- R13: `in_ready` is low throughout frequency setup and in the cycle after a command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Byte stream data |
| setup_seen | input | 1 | Pulse: receiver saw a setup/reset sequence |
| abort | input | 1 | Pulse: receiver saw a line-idle abort |
| line_edge | input | 1 | Pulse: any line edge, used to wake from Sleep |
| last_cycle_done | input | 1 | Output clock is at a cycle boundary |
| recal_done | input | 1 | Pulse: recalibration finished |
| out_en | output | 1 | Output clock driver enable |
| vco_pd | output | 1 | Oscillator and resonator power-down |
| core_pd | output | 1 | Core power-down (retention only) |
| recal_req | output | 1 | Recalibration request |
| mode | output | 3 | Mode: 0 Run, 1 Stop, 2 Doze, 3 Sleep, 4 setup |
| base_freq | output | FREQ_W | Base frequency word (IEEE-754 Hz) |
| freq_offset | output | OFF_W | Signed offset in 2^-25 steps |
| drive | output | DRV_W | Drive-strength code |
| low_jitter | output | 1 | 1 = low jitter, 0 = low power |

## Verification
The collision that matters is a `setup_seen` or `abort` pulse arriving in the same cycle as the final argument byte of OffsetFreq or NewFreq. In that case the discard must win over execution. The bench provokes this by raising the control pulse together with `in_valid` on that last byte. The outcome is judged at the ports in two ways. First, the offset or base word must be unchanged. Second, a DrvStrength command sent right afterwards must take effect, which proves the parser restarted at an opcode. A second overlap is a PwrJitter write held across a Run command that also applies held frequency settings. Here the bench checks that both updates land in the same step.

// File: rtl/osc_cmd_pkg.sv
package osc_cmd_pkg;

  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_STOP  = 3'd1,
    M_DOZE  = 3'd2,
    M_SLEEP = 3'd3,
    M_SETUP = 3'd4
  } mode_e;

  localparam logic [7:0] OP_RUN   = 8'h50;
  localparam logic [7:0] OP_STOP  = 8'h18;
  localparam logic [7:0] OP_DOZE  = 8'h20;
  localparam logic [7:0] OP_SLEEP = 8'h30;
  localparam logic [7:0] OP_NEWF  = 8'h0C;
  localparam logic [7:0] OP_ORIGF = 8'h10;
  localparam logic [7:0] OP_OFFS  = 8'h3A;
  localparam logic [7:0] OP_DRV   = 8'h41;
  localparam logic [7:0] OP_PWR   = 8'h49;
  localparam logic [7:0] OP_NOP   = 8'h00;

  // number of argument bytes that follow an opcode; unknown codes take none
  function automatic logic [2:0] arg_count(input logic [7:0] op);
    case (op)
      OP_NEWF:        arg_count = 3'd4;
      OP_OFFS:        arg_count = 3'd2;
      OP_DRV, OP_PWR: arg_count = 3'd1;
      default:        arg_count = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/osc_cmd_parser.sv
module osc_cmd_parser
  import osc_cmd_pkg::*;
#(
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [7:0]       data,
  input  logic             setup_seen,
  input  logic             abort,
  input  logic             sleeping,
  output logic             exec_v,
  output logic [7:0]       exec_op,
  output logic [ARG_W-1:0] exec_arg
);

  logic             armed;
  logic             busy;
  logic [2:0]       remain;
  logic [7:0]       op_q;
  logic [ARG_W-1:0] acc;
  logic [ARG_W-1:0] acc_nxt;

  assign acc_nxt = {acc[ARG_W-9:0], data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      busy     <= 1'b0;
      remain   <= '0;
      op_q     <= '0;
      acc      <= '0;
      exec_v   <= 1'b0;
      exec_op  <= '0;
      exec_arg <= '0;
    end else begin
      exec_v <= 1'b0;
      // arming: lost on Sleep, regained only by a fresh setup sequence
      if (sleeping)        armed <= 1'b0;
      else if (setup_seen) armed <= 1'b1;

      if (sleeping || setup_seen || abort) begin
        busy <= 1'b0;                      // partial command discarded
      end else if (take && armed) begin
        if (!busy) begin
          op_q <= data;
          acc  <= '0;
          if (arg_count(data) == 3'd0) begin
            exec_v   <= 1'b1;
            exec_op  <= data;
            exec_arg <= '0;
          end else begin
            busy   <= 1'b1;
            remain <= arg_count(data);
          end
        end else begin
          acc    <= acc_nxt;
          remain <= remain - 3'd1;
          if (remain == 3'd1) begin
            exec_v   <= 1'b1;
            exec_op  <= op_q;
            exec_arg <= acc_nxt;
            busy     <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/osc_mode_fsm.sv
module osc_mode_fsm
  import osc_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec_v,
  input  logic [7:0] exec_op,
  input  logic       recal_done,
  input  logic       line_edge,
  input  logic       last_cycle_done,
  input  logic       pend_base_v,
  output mode_e      mode,
  output logic       mode_chg,
  output logic       apply_pend,
  output logic       out_en,
  output logic       recal_req,
  output logic       vco_pd,
  output logic       core_pd
);

  mode_e nxt;
  logic  run_again;

  always_comb begin
    nxt        = mode;
    run_again  = 1'b0;
    apply_pend = 1'b0;
    case (mode)
      M_RUN: if (exec_v) begin
        case (exec_op)
          OP_STOP:           nxt = M_STOP;
          OP_DOZE:           nxt = M_DOZE;
          OP_SLEEP:          nxt = M_SLEEP;
          OP_NEWF, OP_ORIGF: nxt = M_SETUP;
          OP_RUN:            run_again = 1'b1;
          default:           nxt = mode;
        endcase
      end
      M_STOP, M_DOZE: if (exec_v) begin
        case (exec_op)
          OP_RUN: begin
            apply_pend = 1'b1;
            nxt        = pend_base_v ? M_SETUP : M_RUN;
          end
          OP_STOP:  nxt = M_STOP;
          OP_DOZE:  nxt = M_DOZE;
          OP_SLEEP: nxt = M_SLEEP;
          default:  nxt = mode;
        endcase
      end
      M_SLEEP: if (line_edge) begin
        apply_pend = 1'b1;
        nxt        = pend_base_v ? M_SETUP : M_RUN;
      end
      M_SETUP: if (recal_done) nxt = M_RUN;
      default: nxt = M_RUN;
    endcase
  end

  assign mode_chg = (nxt != mode) || run_again;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_RUN;
      out_en <= 1'b1;
    end else begin
      mode <= nxt;
      // driver follows the mode, but only drops at an output cycle boundary
      if (mode == M_RUN)        out_en <= 1'b1;
      else if (last_cycle_done) out_en <= 1'b0;
    end
  end

  assign recal_req = (mode == M_SETUP);
  assign vco_pd    = ((mode == M_DOZE) || (mode == M_SLEEP)) && !out_en;
  assign core_pd   = (mode == M_SLEEP) && !out_en;

endmodule

// File: rtl/osc_cfg_store.sv
module osc_cfg_store
  import osc_cmd_pkg::*;
#(
  parameter int              FREQ_W         = 32,
  parameter int              OFF_W          = 16,
  parameter int              DRV_W          = 3,
  parameter logic [FREQ_W-1:0] FACTORY_FREQ = '0,
  parameter logic [DRV_W-1:0]  DEF_DRIVE    = '0,
  parameter logic            DEF_LOW_JITTER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_v,
  input  logic [7:0]        exec_op,
  input  logic [FREQ_W-1:0] exec_arg,
  input  mode_e             mode,
  input  logic              mode_chg,
  input  logic              apply_pend,
  output logic [FREQ_W-1:0] base_freq,
  output logic [OFF_W-1:0]  freq_offset,
  output logic [DRV_W-1:0]  drive,
  output logic              low_jitter,
  output logic              pend_base_v
);

  localparam int DRV_MAX = (1 << DRV_W) - 1;

  logic [FREQ_W-1:0] pend_base;
  logic [OFF_W-1:0]  pend_off;
  logic              pend_off_v;
  logic              pend_lj;
  logic              pend_lj_v;
  logic              idle_mode;
  logic [FREQ_W-1:0] new_base;

  assign idle_mode = (mode == M_STOP) || (mode == M_DOZE);
  assign new_base  = (exec_op == OP_NEWF) ? exec_arg : FACTORY_FREQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_freq   <= FACTORY_FREQ;
      freq_offset <= '0;
      drive       <= DEF_DRIVE;
      low_jitter  <= DEF_LOW_JITTER;
      pend_base   <= '0;
      pend_base_v <= 1'b0;
      pend_off    <= '0;
      pend_off_v  <= 1'b0;
      pend_lj     <= 1'b0;
      pend_lj_v   <= 1'b0;
    end else begin
      if (apply_pend) begin
        if (pend_base_v) base_freq   <= pend_base;
        if (pend_off_v)  freq_offset <= pend_off;
        pend_base_v <= 1'b0;
        pend_off_v  <= 1'b0;
      end
      if (mode_chg && pend_lj_v) begin
        low_jitter <= pend_lj;
        pend_lj_v  <= 1'b0;
      end
      if (exec_v) begin
        case (exec_op)
          OP_NEWF, OP_ORIGF: begin
            if (mode == M_RUN) begin
              base_freq   <= new_base;
              freq_offset <= '0;
            end else if (idle_mode) begin
              pend_base   <= new_base;
              pend_base_v <= 1'b1;
              pend_off    <= '0;
              pend_off_v  <= 1'b1;
            end
          end
          OP_OFFS: begin
            if (mode == M_RUN) begin
              freq_offset <= exec_arg[OFF_W-1:0];
            end else if (idle_mode) begin
              pend_off   <= exec_arg[OFF_W-1:0];
              pend_off_v <= 1'b1;
            end
          end
          OP_DRV: if (exec_arg <= DRV_MAX) drive <= exec_arg[DRV_W-1:0];
          OP_PWR: begin
            pend_lj   <= exec_arg[0];
            pend_lj_v <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/osc_cmd_ctrl.sv
module osc_cmd_ctrl
  import osc_cmd_pkg::*;
#(
  parameter int                FREQ_W         = 32,
  parameter int                OFF_W          = 16,
  parameter int                DRV_W          = 3,
  parameter logic [FREQ_W-1:0] FACTORY_FREQ   = 32'h4B18_9680,
  parameter logic [DRV_W-1:0]  DEF_DRIVE      = 3'd3,
  parameter logic              DEF_LOW_JITTER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              setup_seen,
  input  logic              abort,
  input  logic              line_edge,
  input  logic              last_cycle_done,
  input  logic              recal_done,
  output logic              out_en,
  output logic              vco_pd,
  output logic              core_pd,
  output logic              recal_req,
  output logic [2:0]        mode,
  output logic [FREQ_W-1:0] base_freq,
  output logic [OFF_W-1:0]  freq_offset,
  output logic [DRV_W-1:0]  drive,
  output logic              low_jitter
);

  mode_e             mode_s;
  logic              exec_v;
  logic [7:0]        exec_op;
  logic [FREQ_W-1:0] exec_arg;
  logic              mode_chg;
  logic              apply_pend;
  logic              pend_base_v;

  assign in_ready = (mode_s != M_SETUP) && !exec_v;
  assign mode     = mode_s;

  osc_cmd_parser #(.ARG_W(FREQ_W)) u_parser (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (in_valid && in_ready),
    .data       (in_data),
    .setup_seen (setup_seen),
    .abort      (abort),
    .sleeping   (mode_s == M_SLEEP),
    .exec_v     (exec_v),
    .exec_op    (exec_op),
    .exec_arg   (exec_arg)
  );

  osc_mode_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .exec_v          (exec_v),
    .exec_op         (exec_op),
    .recal_done      (recal_done),
    .line_edge       (line_edge),
    .last_cycle_done (last_cycle_done),
    .pend_base_v     (pend_base_v),
    .mode            (mode_s),
    .mode_chg        (mode_chg),
    .apply_pend      (apply_pend),
    .out_en          (out_en),
    .recal_req       (recal_req),
    .vco_pd          (vco_pd),
    .core_pd         (core_pd)
  );

  osc_cfg_store #(
    .FREQ_W(FREQ_W), .OFF_W(OFF_W), .DRV_W(DRV_W),
    .FACTORY_FREQ(FACTORY_FREQ), .DEF_DRIVE(DEF_DRIVE), .DEF_LOW_JITTER(DEF_LOW_JITTER)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_v      (exec_v),
    .exec_op     (exec_op),
    .exec_arg    (exec_arg),
    .mode        (mode_s),
    .mode_chg    (mode_chg),
    .apply_pend  (apply_pend),
    .base_freq   (base_freq),
    .freq_offset (freq_offset),
    .drive       (drive),
    .low_jitter  (low_jitter),
    .pend_base_v (pend_base_v)
  );

endmodule

// File: rtl/osc_cmd_ctrl_chk.sv
module osc_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       out_en,
  input logic       recal_done,
  input logic       last_cycle_done,
  input logic       line_edge,
  input logic       low_jitter,
  input logic       exec_v
);

  a_r5_oe_fall_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en) |-> $past(last_cycle_done));

  a_r5_run_enables_output: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |=> out_en);

  a_r6_setup_waits_recal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !recal_done) |=> (mode == 3'd4));

  a_r11_sleep_until_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !line_edge) |=> (mode == 3'd3));

  a_r9_pwr_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(mode) && !$past(exec_v)) |-> $stable(low_jitter));

endmodule

bind osc_cmd_ctrl osc_cmd_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode            (mode),
  .out_en          (out_en),
  .recal_done      (recal_done),
  .last_cycle_done (last_cycle_done),
  .line_edge       (line_edge),
  .low_jitter      (low_jitter),
  .exec_v          (exec_v)
);

// File: tb/osc_cmd_ctrl_tb.sv
module osc_cmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FACT = 32'h4B18_9680;
  localparam int S_RUN = 0, S_STOP = 1, S_DOZE = 2, S_SLEEP = 3, S_SETUP = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, setup_seen = 0, abort = 0, line_edge = 0;
  logic last_cycle_done = 1, recal_done = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_en, vco_pd, core_pd, recal_req, low_jitter;
  logic [2:0] mode, drive;
  logic [31:0] base_freq;
  logic [15:0] freq_offset;

  osc_cmd_ctrl u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int m_mode; bit m_armed, m_lj, p_lj, p_lj_v, p_b_v, p_o_v;
  logic [31:0] m_base, p_b; logic [15:0] m_off, p_o; logic [2:0] m_drv;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  function automatic int nargs(input logic [7:0] op);
    case (op) 8'h0C: return 4; 8'h3A: return 2; 8'h41, 8'h49: return 1; default: return 0; endcase
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h0C, 8'h10: return "R6"; 8'h3A: return "R8"; 8'h41: return "R10";
      8'h49: return "R9"; 8'h18, 8'h20, 8'h30: return "R5"; default: return "R3";
    endcase
  endfunction

  task automatic m_change(input int nm, input bit again);
    if ((nm != m_mode || again) && p_lj_v) begin m_lj = p_lj; p_lj_v = 0; end
    m_mode = nm;
  endtask

  task automatic m_resume();
    bit had = p_b_v;
    if (p_b_v) m_base = p_b;
    if (p_o_v) m_off = p_o;
    p_b_v = 0; p_o_v = 0;
    m_change(had ? S_SETUP : S_RUN, 0);
  endtask

  task automatic m_exec(input logic [7:0] op, input logic [31:0] arg);
    bit idle = (m_mode == S_STOP || m_mode == S_DOZE);
    if (!m_armed || m_mode == S_SLEEP || m_mode == S_SETUP) return;
    case (op)
      8'h50: if (m_mode == S_RUN) m_change(S_RUN, 1); else m_resume();
      8'h18: m_change(S_STOP, 0);
      8'h20: m_change(S_DOZE, 0);
      8'h30: begin m_change(S_SLEEP, 0); m_armed = 0; end
      8'h0C, 8'h10: begin
        logic [31:0] v = (op == 8'h0C) ? arg : FACT;
        if (m_mode == S_RUN) begin m_base = v; m_off = 0; m_change(S_SETUP, 0); end
        else if (idle) begin p_b = v; p_b_v = 1; p_o = 0; p_o_v = 1; end
      end
      8'h3A: if (m_mode == S_RUN) m_off = arg[15:0]; else if (idle) begin p_o = arg[15:0]; p_o_v = 1; end
      8'h41: if (arg <= 7) m_drv = arg[2:0];
      8'h49: begin p_lj = arg[0]; p_lj_v = 1; end
      default: ;
    endcase
  endtask

  task automatic send_byte_ctl(input logic [7:0] b, input bit s, input bit a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b; setup_seen = s; abort = a;
    @(negedge clk);
    in_valid = 0; setup_seen = 0; abort = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_byte_ctl(b, 0, 0);
  endtask

  task automatic check_all(input string req);
    chk(req, "mode", {29'd0, mode}, m_mode);
    chk(req, "base", base_freq, m_base);
    chk(req, "offset", {16'd0, freq_offset}, {16'd0, m_off});
    chk(req, "drive", {29'd0, drive}, {29'd0, m_drv});
    chk(req, "low_jitter", {31'd0, low_jitter}, {31'd0, m_lj});
    chk(req, "out_en", {31'd0, out_en}, (m_mode == S_RUN));
    chk(req, "vco_pd", {31'd0, vco_pd}, (m_mode == S_DOZE || m_mode == S_SLEEP));
    chk(req, "core_pd", {31'd0, core_pd}, (m_mode == S_SLEEP));
  endtask

  task automatic settle(input string req);
    repeat (3) @(posedge clk);
    if (m_mode == S_SETUP) begin
      @(negedge clk);
      chk("R6", "recal_req", {31'd0, recal_req}, 1);
      chk("R13", "in_ready in setup", {31'd0, in_ready}, 0);
      recal_done = 1;
      @(negedge clk);
      recal_done = 0;
      m_change(S_RUN, 0);
      repeat (3) @(posedge clk);
    end
    @(negedge clk);
    check_all(req);
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [31:0] arg);
    int n = nargs(op);
    send_byte(op);
    for (int i = n - 1; i >= 0; i--) send_byte(arg[8*i +: 8]);
    m_exec(op, arg);
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [31:0] arg, input string req);
    send_cmd(op, arg);
    settle(req);
  endtask

  task automatic pulse_setup();
    @(negedge clk); setup_seen = 1;
    @(negedge clk); setup_seen = 0;
    if (m_mode != S_SLEEP) m_armed = 1;
  endtask

  task automatic wake(input string req);
    @(negedge clk); line_edge = 1;
    @(negedge clk); line_edge = 0;
    m_resume();
    settle(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_mode = S_RUN; m_armed = 0; m_lj = 0; p_lj = 0; p_lj_v = 0; p_b_v = 0; p_o_v = 0;
    m_base = FACT; p_b = 0; m_off = 0; p_o = 0; m_drv = 3'd3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    chk("R1", "recal_req", {31'd0, recal_req}, 0);

    // R2 commands before any setup sequence are dropped
    do_cmd(8'h18, 0, "R2");
    do_cmd(8'h41, 32'd6, "R2");
    pulse_setup();

    // R10 drive strength range
    do_cmd(8'h41, 32'd5, "R10");
    do_cmd(8'h41, 32'd9, "R10");

    // R8 absolute offset
    do_cmd(8'h3A, 32'h1234, "R8");
    do_cmd(8'h3A, 32'hFFF0, "R8");

    // R9 power/jitter held until mode change, Run in Run counts
    do_cmd(8'h49, 32'd1, "R9");
    chk("R9", "lj still held", {31'd0, low_jitter}, 0);
    do_cmd(8'h50, 0, "R9");

    // R3 unknown opcode then a real one; NoOp
    do_cmd(8'h77, 0, "R3");
    do_cmd(8'h00, 0, "R3");
    do_cmd(8'h41, 32'd4, "R3");

    // R5 output enable waits for cycle boundary
    last_cycle_done = 0;
    send_cmd(8'h18, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R5", "mode stop", {29'd0, mode}, S_STOP);
    chk("R5", "out_en held", {31'd0, out_en}, 1);
    last_cycle_done = 1;
    @(negedge clk);
    chk("R5", "out_en dropped", {31'd0, out_en}, 0);

    // R7 deferred frequency in Stop, last wins, with held PwrJitter
    do_cmd(8'h0C, 32'h4A00_0000, "R7");
    do_cmd(8'h3A, 32'h0042, "R7");
    do_cmd(8'h0C, 32'h4B00_1234, "R7");
    do_cmd(8'h3A, 32'h0077, "R7");
    do_cmd(8'h49, 32'd0, "R7");
    do_cmd(8'h50, 0, "R7");

    // R6 NewFreq in Run (MSB-first assembly, R3 too) then OriginalFreq
    do_cmd(8'h3A, 32'h0101, "R8");
    do_cmd(8'h0C, 32'h4C11_2233, "R6");
    do_cmd(8'h10, 0, "R6");

    // R4 discard by setup between args, in same cycle as last byte, and by abort
    send_byte(8'h0C); send_byte(8'h11); send_byte(8'h22);
    pulse_setup();
    do_cmd(8'h41, 32'd2, "R4");
    send_byte(8'h3A); send_byte_ctl(8'h55, 0, 0); send_byte_ctl(8'h66, 1, 0);
    m_armed = 1;
    do_cmd(8'h41, 32'd1, "R4");
    send_byte(8'h0C); send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    send_byte_ctl(8'h04, 0, 1);
    do_cmd(8'h41, 32'd7, "R4");

    // R12 Doze power-down; R11 Sleep and wake
    do_cmd(8'h20, 0, "R12");
    do_cmd(8'h30, 0, "R12");
    pulse_setup();
    send_byte(8'h41); send_byte(8'h00);
    settle("R11");
    wake("R11");
    do_cmd(8'h41, 32'd3, "R11");
    pulse_setup();
    do_cmd(8'h41, 32'd6, "R11");

    // R7 deferred across Doze with OriginalFreq, then R13 via settle
    do_cmd(8'h0C, 32'h4D00_0000, "R7");
    do_cmd(8'h20, 0, "R7");
    do_cmd(8'h10, 0, "R7");
    do_cmd(8'h50, 0, "R13");

    // constrained random commands
    for (int i = 0; i < 250; i++) begin
      logic [7:0] ops [10] = '{8'h50, 8'h18, 8'h20, 8'h30, 8'h0C, 8'h10, 8'h3A, 8'h41, 8'h49, 8'h00};
      logic [7:0] op = ops[$urandom_range(0, 9)];
      logic [31:0] arg = $urandom;
      if (op == 8'h41) arg = $urandom_range(0, 12);
      if (op == 8'h30 && $urandom_range(0, 3) != 0) op = 8'h18;
      do_cmd(op, arg, tag_of(op));
      if (m_mode == S_SLEEP) begin
        wake("R11");
        pulse_setup();
      end
    end

    summary();
  end
endmodule